// File: doc/BRIEF.md
# Ternary Hebbian Weight Update Unit

This block performs one simplified Hebbian learning step on the column of weights that feed a single output neuron. A row of parallel learning lanes, one for each input, first loads its weight from synaptic memory. In the same cycle it loads a shared per-neuron learning scalar and a 2-bit ternary code taken from that input's neural state. Each lane then adds the scalar to its weight, subtracts it, or keeps the weight, and the whole column is written back together. The usual multiply in the Hebbian rule is therefore reduced to a three-way choice.

A finer approximation of the full-precision rule comes from applying the ternary step several times to the same weights. A repeat count given with the start request sets how many steps are applied between the load and the write-back. Results clamp at the signed limits of the weight word and never wrap. The caller supplies the scalar and the training schedule.

Top module: `hebb_ternary_update`

## Requirements
- R1: After reset the unit is idle: `busy`, `rd_en`, `wr_en` and `done` are all 0.
- R2: A lane whose code is 2'b01 adds the signed scalar `delta_in` to its weight once per repeat.
- R3: A lane whose code is 2'b11 subtracts the signed scalar `delta_in` from its weight once per repeat.
- R4: A lane whose code is 2'b00 or 2'b10 writes back its loaded weight unchanged.
- R5: A result above the largest signed 16-bit value (32767) is written as 32767.
- R6: A result below the smallest signed 16-bit value (-32768) is written as -32768.
- R7: All 16 lanes update in the same step, each one following its own code. Lane j uses bits [2j+1:2j] of `state_codes` and weight bits [16j+15:16j].
- R8: With a repeat count of R, the step is applied R times to the same weights. With R = 0 the loaded weights are written back unchanged.
- R9: `start` is accepted in the idle state on a clock edge. `rd_en` is high for the next cycle, and the weight, scalar, code and repeat inputs are sampled at the end of that cycle. `wr_en` is high for one cycle, R+2 cycles after acceptance, with the results on `w_wr_data`. `done` is high for the single cycle after that, and the unit is idle again in the cycle after `done`.
- R10: `start` is ignored while `busy` is high. A pulse during a run neither changes that run's timing or results nor starts a second run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one learning step sequence |
| rep_cnt | input | 4 | Number of ternary steps to apply |
| delta_in | input | 16 | Signed learning scalar for the selected output neuron |
| state_codes | input | 32 | 2-bit ternary code per input lane |
| rd_en | output | 1 | Weight column read strobe; inputs sampled at the end of this cycle |
| w_rd_data | input | 256 | Weight column read from synaptic memory |
| busy | output | 1 | A sequence is in progress |
| wr_en | output | 1 | Write-back strobe for the updated column |
| w_wr_data | output | 256 | Updated weight column |
| done | output | 1 | One-cycle completion strobe after write-back |

## Verification
The hardest case to reach is a clamp that happens partway through a repeated sequence. A weight near a limit must cross it on an intermediate step, and the later steps must keep it pinned at the limit rather than wrap. The stimulus starts weights a few counts from each limit and requests several repeats, so that the crossing falls in the middle of the sequence. It also pairs the most negative scalar with the most negative and most positive weights, because those pairings need the widest intermediate sum. A start pulse placed in the middle of a run checks that the run's timing is unchanged and that only one write-back occurs.

// File: rtl/hebb_pkg.sv
package hebb_pkg;
   typedef enum logic [1:0] {
      LC_HOLD = 2'b00,
      LC_INC  = 2'b01,
      LC_RSV  = 2'b10,
      LC_DEC  = 2'b11
   } lane_code_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LOAD,
      SQ_STEP,
      SQ_WBACK,
      SQ_DONE
   } seq_state_e;
endpackage

// File: rtl/hebb_lane.sv
module hebb_lane #(
   parameter int W_W      = 16,
   parameter int DELTA_W  = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [W_W-1:0]     w_in,
   input  logic [DELTA_W-1:0] delta,
   input  logic [1:0]         code,
   output logic [W_W-1:0]     w_q
);
   import hebb_pkg::*;

   localparam int XW = W_W + 2;

   logic [XW-1:0]  w_ext, d_ext, sum;
   logic [W_W-1:0] nxt;
   logic           apply;

   assign w_ext = {{2{w_q[W_W-1]}}, w_q};
   assign d_ext = {{(XW-DELTA_W){delta[DELTA_W-1]}}, delta};
   assign apply = (code == LC_INC) || (code == LC_DEC);
   assign sum   = (code == LC_DEC) ? (w_ext - d_ext) : (w_ext + d_ext);

   generate
      if (SATURATE) begin : g_sat
         logic ovf;
         assign ovf = !((&sum[XW-1:W_W-1]) || !(|sum[XW-1:W_W-1]));
         always_comb begin
            if (!ovf)
               nxt = sum[W_W-1:0];
            else if (sum[XW-1])
               nxt = {1'b1, {(W_W-1){1'b0}}};
            else
               nxt = {1'b0, {(W_W-1){1'b1}}};
         end
      end else begin : g_wrap
         assign nxt = sum[W_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         w_q <= '0;
      else if (load)
         w_q <= w_in;
      else if (step && apply)
         w_q <= nxt;
   end
endmodule

// File: rtl/hebb_seq.sv
module hebb_seq #(
   parameter int REP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [REP_W-1:0] rep_cnt,
   output logic             load,
   output logic             step,
   output logic             wback,
   output logic             fin,
   output logic             busy
);
   import hebb_pkg::*;

   seq_state_e       st;
   logic [REP_W-1:0] rep_q, cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SQ_IDLE;
         rep_q <= '0;
         cnt   <= '0;
      end else begin
         case (st)
            SQ_IDLE:  if (start) st <= SQ_LOAD;
            SQ_LOAD: begin
               rep_q <= rep_cnt;
               cnt   <= '0;
               st    <= (rep_cnt == '0) ? SQ_WBACK : SQ_STEP;
            end
            SQ_STEP: begin
               if (cnt == rep_q - 1'b1) st <= SQ_WBACK;
               else cnt <= cnt + 1'b1;
            end
            SQ_WBACK: st <= SQ_DONE;
            SQ_DONE:  st <= SQ_IDLE;
            default:  st <= SQ_IDLE;
         endcase
      end
   end

   assign load  = (st == SQ_LOAD);
   assign step  = (st == SQ_STEP);
   assign wback = (st == SQ_WBACK);
   assign fin   = (st == SQ_DONE);
   assign busy  = (st != SQ_IDLE);
endmodule

// File: rtl/hebb_ternary_update.sv
module hebb_ternary_update #(
   parameter int N_LANE   = 16,
   parameter int W_W      = 16,
   parameter int DELTA_W  = 16,
   parameter int REP_W    = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [REP_W-1:0]       rep_cnt,
   input  logic [DELTA_W-1:0]     delta_in,
   input  logic [2*N_LANE-1:0]    state_codes,
   output logic                   rd_en,
   input  logic [N_LANE*W_W-1:0]  w_rd_data,
   output logic                   busy,
   output logic                   wr_en,
   output logic [N_LANE*W_W-1:0]  w_wr_data,
   output logic                   done
);
   generate
      if (DELTA_W > W_W) begin : g_bad_delta
         $error("DELTA_W must not exceed W_W");
      end
      if (N_LANE < 1 || W_W < 2 || REP_W < 1) begin : g_bad_size
         $error("N_LANE, W_W and REP_W out of range");
      end
   endgenerate

   logic load, step;

   hebb_seq #(.REP_W(REP_W)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .rep_cnt (rep_cnt),
      .load    (load),
      .step    (step),
      .wback   (wr_en),
      .fin     (done),
      .busy    (busy)
   );

   assign rd_en = load;

   logic [DELTA_W-1:0] delta_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    delta_q <= '0;
      else if (load) delta_q <= delta_in;
   end

   generate
      for (genvar j = 0; j < N_LANE; j++) begin : g_lane
         logic [1:0] code_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    code_q <= '0;
            else if (load) code_q <= state_codes[2*j +: 2];
         end
         hebb_lane #(.W_W(W_W), .DELTA_W(DELTA_W), .SATURATE(SATURATE)) i_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .step  (step),
            .w_in  (w_rd_data[W_W*j +: W_W]),
            .delta (delta_q),
            .code  (code_q),
            .w_q   (w_wr_data[W_W*j +: W_W])
         );
      end
   endgenerate
endmodule

// File: rtl/hebb_ternary_update_chk.sv
module hebb_ternary_update_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic rd_en,
   input logic busy,
   input logic wr_en,
   input logic done
);
   assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_en, wr_en, done}));

   assert_read_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> rd_en);

   assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (done && !wr_en));

   assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && !rd_en));
endmodule

bind hebb_ternary_update hebb_ternary_update_chk i_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .rd_en (rd_en),
   .busy  (busy),
   .wr_en (wr_en),
   .done  (done)
);

// File: tb/test_hebb_ternary_update.sv
module test_hebb_ternary_update;
   localparam int N = 16;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    rep_cnt = '0;
   logic [15:0]   delta_in = '0;
   logic [2*N-1:0] state_codes = '0;
   logic [N*W-1:0] w_rd_data = '0;
   logic          rd_en, busy, wr_en, done;
   logic [N*W-1:0] w_wr_data;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   hebb_ternary_update i_hebb_ternary_update (
      .clk(clk), .rst_n(rst_n), .start(start), .rep_cnt(rep_cnt),
      .delta_in(delta_in), .state_codes(state_codes), .rd_en(rd_en),
      .w_rd_data(w_rd_data), .busy(busy), .wr_en(wr_en),
      .w_wr_data(w_wr_data), .done(done)
   );

   // {weight, delta, code, repeats, expected}
   localparam int NV = 12;
   localparam logic [53:0] VEC [NV] = '{
      {16'h0064, 16'h0005, 2'b01, 4'd1,  16'h0069},  // R2
      {16'h0064, 16'h0005, 2'b11, 4'd1,  16'h005F},  // R3
      {16'h0064, 16'h0005, 2'b00, 4'd3,  16'h0064},  // R4
      {16'h0064, 16'h0005, 2'b10, 4'd3,  16'h0064},  // R4
      {16'h7FF8, 16'h0005, 2'b01, 4'd3,  16'h7FFF},  // R5
      {16'h8003, 16'h0005, 2'b11, 4'd2,  16'h8000},  // R6
      {16'h0000, 16'h0007, 2'b01, 4'd4,  16'h001C},  // R8
      {16'h0032, 16'h0009, 2'b01, 4'd0,  16'h0032},  // R8
      {16'hFFF6, 16'hFFFD, 2'b01, 4'd2,  16'hFFF0},  // R2
      {16'h7FFF, 16'h8000, 2'b11, 4'd1,  16'h7FFF},  // R5
      {16'h8000, 16'h8000, 2'b01, 4'd1,  16'h8000},  // R6
      {16'hFFFF, 16'h0001, 2'b11, 4'd15, 16'hFFF0}   // R8
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Runs one sequence; returns cycles from acceptance to wr_en and the column.
   task automatic run(input logic [N*W-1:0] w, input logic [15:0] d,
                      input logic [2*N-1:0] codes, input logic [3:0] rep,
                      input bit poke_mid, output int cyc, output logic [N*W-1:0] res);
      @(negedge clk);
      w_rd_data = w; delta_in = d; state_codes = codes; rep_cnt = rep;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      check("R9 rd_en", {15'd0, rd_en}, 16'd1);
      while (!wr_en && cyc < 100) begin
         @(negedge clk);
         cyc++;
         if (poke_mid && cyc == 3) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      res = w_wr_data;
      check("R9 wr_en timing", 16'(cyc), 16'(rep + 2));
      @(negedge clk);
      check("R9 done", {15'd0, done}, 16'd1);
      @(negedge clk);
      check("R9 idle", {15'd0, busy}, 16'd0);
   endtask

   initial begin
      int cyc;
      logic [N*W-1:0] res, wcol;
      logic [2*N-1:0] codes;
      logic [W-1:0] expv;

      repeat (3) @(negedge clk);
      check("R1 busy", {15'd0, busy}, 16'd0);
      check("R1 strobes", {13'd0, rd_en, wr_en, done}, 16'd0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         codes = '0;
         for (int j = 0; j < N; j++) begin
            wcol[W*j +: W] = VEC[v][53:38];
            codes[2*j +: 2] = VEC[v][21:20];
         end
         run(wcol, VEC[v][37:22], codes, VEC[v][19:16], 1'b0, cyc, res);
         for (int j = 0; j < N; j++)
            check($sformatf("vector %0d lane %0d R2-R6/R8", v, j), res[W*j +: W], VEC[v][15:0]);
      end

      // R7: lanes with distinct weights and codes in one step
      for (int j = 0; j < N; j++) begin
         wcol[W*j +: W] = 16'(j * 100);
         codes[2*j +: 2] = 2'(j % 4);
      end
      run(wcol, 16'd3, codes, 4'd2, 1'b0, cyc, res);
      for (int j = 0; j < N; j++) begin
         case (j % 4)
            1: expv = 16'(j * 100 + 6);
            3: expv = 16'(j * 100 - 6);
            default: expv = 16'(j * 100);
         endcase
         check($sformatf("R7 lane %0d", j), res[W*j +: W], expv);
      end

      // R10: start pulse mid-run is ignored
      for (int j = 0; j < N; j++) begin
         wcol[W*j +: W] = 16'h0010;
         codes[2*j +: 2] = 2'b01;
      end
      run(wcol, 16'd1, codes, 4'd5, 1'b1, cyc, res);
      check("R10 result", res[15:0], 16'h0015);
      repeat (3) begin
         @(negedge clk);
         check("R10 no second run", {14'd0, busy, wr_en}, 16'd0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule